// File: doc/BRIEF.md
# Runtime-Partitioned SIMD Adder

This block adds two 16-bit words. A 4-bit partition mask, which may change on any cycle, decides where the carry chain is broken. With no boundary enabled the block is one 16-bit adder. With only the middle boundary enabled it is two independent 8-bit adders. With every boundary enabled it is four independent 4-bit adders. Each lane keeps its own sum. The carry out of each lane is dropped, so it never reaches the lane above.

The datapath is built from 4-bit adder slices. Between each pair of neighbouring slices sits a carry gate, and a partition mask bit controls that gate. The block has no clock and no registers: the sum follows the operands and the mask within the same cycle. It is meant to sit inside a packed-integer execution stage, where the instruction's element size picks the mask.

Top module: `simd_lane_adder`

## Requirements
- R1: With part_mask[2:0] = 3'b000, sum equals (a + b) modulo 2^16.
- R2: part_mask bit 0 blocks the carry from bit 3 into bit 4. With part_mask = 4'b0001, sum[3:0] = (a[3:0] + b[3:0]) mod 16 and sum[15:4] = (a[15:4] + b[15:4]) mod 2^12.
- R3: part_mask bit 1 blocks the carry from bit 7 into bit 8. With part_mask = 4'b0010, bits 15:8 and 7:0 each hold the 8-bit sum of their own operand bytes.
- R4: part_mask bit 2 blocks the carry from bit 11 into bit 12. With part_mask = 4'b0100, sum[11:0] and sum[15:12] are independent sums of their own fields.
- R5: With part_mask[2:0] = 3'b111, each 4-bit nibble of sum is the 4-bit sum of the matching operand nibbles.
- R6: part_mask bit 3 has no effect. For any a, b and m, the sum with part_mask = m equals the sum with part_mask = m with bit 3 flipped.
- R7: Every lane's carry out is discarded. Examples: 0xFFFF + 0x0001 gives 0x0000 with mask 0, and 0xFFFF + 0x1111 gives 0x0000 with mask 4'b1111.
- R8: The block is combinational. sum reflects new a, b and part_mask values in the same cycle they are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand word |
| b | input | 16 | Second operand word |
| part_mask | input | 4 | Boundary enables. Bit i cuts the carry between bits 4i+3 and 4i+4. Bit 3 is unused. |
| sum | output | 16 | Lane-wise sums, with each lane's carry out dropped |

## Verification
The hardest case to reach is a carry that would cross an enabled boundary and has to be stopped there. It only shows up when the lane below the boundary overflows. Ordinary operand values rarely make a lane overflow exactly at one chosen boundary while the other boundaries stay off. The stimulus therefore uses all-ones fields plus one (0x000F + 0x0001, 0x0FFF + 0x0001, 0x12FF + 0x3401), which force a carry out of exactly one lane. It applies these under single-boundary masks and under the full and fully split modes. It also runs random operand pairs under all sixteen mask values and compares each result with a mask-based lane model.

// File: rtl/simd_lane_pkg.sv
package simd_lane_pkg;
  localparam int unsigned SLICE_W    = 4;
  localparam int unsigned NUM_SLICES = 4;
  localparam int unsigned DATA_W     = SLICE_W * NUM_SLICES;
  localparam int unsigned NUM_CUTS   = NUM_SLICES - 1;

  typedef logic [SLICE_W-1:0] slice_t;
endpackage

// File: rtl/lane_cut_decoder.sv
module lane_cut_decoder #(
  parameter int unsigned NUM_SLICES = 4,
  localparam int unsigned NUM_CUTS = NUM_SLICES - 1
) (
  input  logic [NUM_SLICES-1:0] part_mask,
  output logic [NUM_CUTS-1:0]   cut_en
);
  // Only boundaries between slices exist; the top mask bit has no boundary.
  always_comb begin
    cut_en = part_mask[NUM_CUTS-1:0];
  end
endmodule

// File: rtl/nibble_add_slice.sv
module nibble_add_slice #(
  parameter int unsigned SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] x,
  input  logic [SLICE_W-1:0] y,
  input  logic               cin,
  output logic [SLICE_W-1:0] s,
  output logic               cout
);
  logic [SLICE_W:0] wide;

  always_comb begin
    wide = {1'b0, x} + {1'b0, y} + {{SLICE_W{1'b0}}, cin};
    s    = wide[SLICE_W-1:0];
    cout = wide[SLICE_W];
  end
endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
  import simd_lane_pkg::*;
(
  input  logic [15:0] a,
  input  logic [15:0] b,
  input  logic [3:0]  part_mask,
  output logic [15:0] sum
);
  logic [NUM_CUTS-1:0]   cut_en;
  logic [NUM_SLICES-1:0] carry_in;
  logic [NUM_SLICES-1:0] carry_out;

  lane_cut_decoder #(.NUM_SLICES(NUM_SLICES)) cut_dec_i (
    .part_mask (part_mask),
    .cut_en    (cut_en)
  );

  assign carry_in[0] = 1'b0;

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    nibble_add_slice #(.SLICE_W(SLICE_W)) slice_i (
      .x    (a[k*SLICE_W +: SLICE_W]),
      .y    (b[k*SLICE_W +: SLICE_W]),
      .cin  (carry_in[k]),
      .s    (sum[k*SLICE_W +: SLICE_W]),
      .cout (carry_out[k])
    );
    if (k > 0) begin : g_gate
      // Enabled boundary drops the carry from the slice below.
      assign carry_in[k] = carry_out[k-1] & ~cut_en[k-1];
    end
    // R5: with every boundary enabled each slice is a standalone add.
    always_comb begin
      if (part_mask[2:0] == 3'b111)
        a_r5_slice_isolated : assert (sum[k*SLICE_W +: SLICE_W] ==
          slice_t'(a[k*SLICE_W +: SLICE_W] + b[k*SLICE_W +: SLICE_W]));
    end
  end

  // Guards for the whole-word and single-boundary modes.
  always_comb begin
    if (part_mask[2:0] == 3'b000)
      a_r1_full_width : assert (sum == 16'(a + b));
    if (part_mask[2:0] == 3'b001)
      a_r2_cut_at_four : assert ((sum[3:0] == 4'(a[3:0] + b[3:0])) &&
                                 (sum[15:4] == 12'(a[15:4] + b[15:4])));
    if (part_mask[2:0] == 3'b010)
      a_r3_two_bytes : assert ((sum[7:0] == 8'(a[7:0] + b[7:0])) &&
                               (sum[15:8] == 8'(a[15:8] + b[15:8])));
    if (part_mask[2:0] == 3'b100)
      a_r4_cut_at_twelve : assert ((sum[11:0] == 12'(a[11:0] + b[11:0])) &&
                                   (sum[15:12] == 4'(a[15:12] + b[15:12])));
  end
endmodule

// File: tb/simd_lane_adder_tb.sv
module simd_lane_adder_tb_top;
  logic clk;
  logic rst_n;
  logic [15:0] a, b;
  logic [3:0]  part_mask;
  logic [15:0] sum;
  int total, bad;
  bit done;

  simd_lane_adder dut_i (.a(a), .b(b), .part_mask(part_mask), .sum(sum));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // a, b, expected full-width sum
  localparam int NV = 8;
  localparam logic [47:0] VEC [NV] = '{
    {16'h0000, 16'h0000, 16'h0000},
    {16'hFFFF, 16'hFFFF, 16'hFFFE},
    {16'h1234, 16'h1234, 16'h2468},
    {16'hABCD, 16'hABCD, 16'h579A},
    {16'hFFFF, 16'h0000, 16'hFFFF},
    {16'h1234, 16'hABCD, 16'hBE01},
    {16'hABCD, 16'hFFFF, 16'hABCC},
    {16'h0000, 16'h1234, 16'h1234}
  };

  function automatic logic [15:0] model(input logic [15:0] x, input logic [15:0] y,
                                        input logic [3:0] m);
    logic [15:0] r;
    int lo;
    r = '0;
    lo = 0;
    for (int hi = 4; hi <= 16; hi += 4) begin
      if (hi == 16 || m[hi/4-1]) begin
        logic [16:0] lm, t;
        lm = ((17'd1 << hi) - 17'd1) ^ ((17'd1 << lo) - 17'd1);
        t  = ({1'b0, x} & lm) + ({1'b0, y} & lm);
        r  = r | 16'(t & lm);
        lo = hi;
      end
    end
    return r;
  endfunction

  task automatic apply_check(input logic [15:0] x, input logic [15:0] y,
                             input logic [3:0] m, input logic [15:0] exp,
                             input string req);
    @(negedge clk);
    a = x; b = y; part_mask = m;
    #1;
    total++;
    if (sum !== exp) begin
      bad++;
      $display("FAIL %s a=%h b=%h mask=%b actual=%h expected=%h", req, x, y, m, sum, exp);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 1'b0;
    a = '0; b = '0; part_mask = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R8: idle zeros give zero sum
    apply_check(16'h0000, 16'h0000, 4'b0000, 16'h0000, "R8 idle");

    // Table walk: full width expected from table (R1), lane modes from model (R3, R5)
    for (int i = 0; i < NV; i++) begin
      apply_check(VEC[i][47:32], VEC[i][31:16], 4'b0000, VEC[i][15:0], "R1 table");
      apply_check(VEC[i][47:32], VEC[i][31:16], 4'b0010,
                  model(VEC[i][47:32], VEC[i][31:16], 4'b0010), "R3 table");
      apply_check(VEC[i][47:32], VEC[i][31:16], 4'b1111,
                  model(VEC[i][47:32], VEC[i][31:16], 4'b1111), "R5 table");
    end

    // Directed boundary cases
    apply_check(16'hFFFF, 16'h0001, 4'b0000, 16'h0000, "R7 top carry dropped");
    apply_check(16'h000F, 16'h0001, 4'b0000, 16'h0010, "R1 carry crosses 3/4");
    apply_check(16'h000F, 16'h0001, 4'b0001, 16'h0000, "R2 cut at 3/4");
    apply_check(16'h12FF, 16'h3401, 4'b0010, 16'h4600, "R3 cut at 7/8");
    apply_check(16'h0FFF, 16'h0001, 4'b0100, 16'h0000, "R4 cut at 11/12");
    apply_check(16'h0FFF, 16'h0001, 4'b0000, 16'h1000, "R4 uncut reference");
    apply_check(16'hFFFF, 16'h1111, 4'b1111, 16'h0000, "R7 nibble carries dropped");
    apply_check(16'h1234, 16'hABCD, 4'b1111, 16'hBDF1, "R5 nibble lanes");
    apply_check(16'hFFFF, 16'h0001, 4'b1000, 16'h0000, "R6 bit3 alone");
    apply_check(16'h1234, 16'hABCD, 4'b1000, 16'hBE01, "R6 bit3 alone");
    apply_check(16'h12FF, 16'h3401, 4'b1010, 16'h4600, "R6 bit3 with byte mode");

    // Random pairs under every mask value; bit3 pairing (R6)
    for (int n = 0; n < 200; n++) begin
      logic [15:0] rx, ry;
      logic [3:0]  rm;
      rx = 16'($urandom);
      ry = 16'($urandom);
      rm = 4'(n % 16);
      apply_check(rx, ry, rm, model(rx, ry, rm), "R2/R3/R4 random lanes");
      apply_check(rx, ry, rm ^ 4'b1000, model(rx, ry, rm), "R6 random bit3 flip");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule